// File: doc/BRIEF.md
# Branch and Skip Target Unit

This block works out the next program counter value for the two control-flow opcode groups of an 8-bit accumulator machine. The first group is the short (page-local) conditional branches, opcodes 0x30 to 0x3F. The second group is the long conditional branches, long skips and the no-op, opcodes 0xC0 to 0xCF. The caller presents one request per cycle. Each request carries the opcode, the condition state (accumulator-is-zero, carry flag, output latch Q, interrupt enable), the external sense lines and the program counter, which already points at the byte after the opcode. It also carries the one or two bytes that follow the opcode in memory.

One cycle later the block returns several results in registers. It gives the next program counter and the number of operand bytes it actually used. It raises a jump indication when a branch target was loaded, and a group-hit indication when the opcode belongs to either control-flow group. Any other opcode passes the program counter through unchanged. In the opcode encoding, bit 3 flips the sense of the test, bit 2 of the 0xCx group separates skips from branches, and the low bits pick the condition.

Top module: `brsk_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next edge leaves `out_valid`, `jump`, `ctl_hit`, `opnd_bytes` and `nxt_pc` all zero. This holds even if `in_valid` is high in the same cycle.
- R2: A request taken with `in_valid` high produces its results with `out_valid` high after exactly one rising edge. A cycle with `in_valid` low drops `out_valid` and leaves the other outputs at their last value.
- R3: Short-branch conditions: 0x30 always, 0x31 Q, 0x32 zero, 0x33 carry, 0x34..0x37 sense lines `ef[0]`..`ef[3]`. Opcodes 0x38..0x3F test the complement of the condition eight codes lower, so 0x38 never branches.
- R4: A short branch whose condition holds gives `nxt_pc` = {`pc_in[15:8]`, `opnd_a`}, with `jump`=1 and `opnd_bytes`=1. The high byte stays the high byte of `pc_in`, even when `pc_in[7:0]` is 0xFF.
- R5: A short branch whose condition fails gives `nxt_pc` = `pc_in`+1 as a full 16-bit increment (0xFFFF wraps to 0x0000), with `jump`=0 and `opnd_bytes`=0.
- R6: Long-branch conditions: 0xC0 always, 0xC1 Q, 0xC2 zero, 0xC3 carry. 0xC8..0xCB are their complements, so 0xC8 never branches and therefore always steps over two bytes.
- R7: A long branch whose condition holds gives `nxt_pc` = {`opnd_a`, `opnd_b`}, where `opnd_a` is the first byte after the opcode and is the high address byte. It also gives `jump`=1 and `opnd_bytes`=2.
- R8: A long branch whose condition fails gives `nxt_pc` = `pc_in`+2 modulo 2^16, with `jump`=0 and `opnd_bytes`=0.
- R9: The skip codes are 0xC4 (never, a no-op), 0xC5 not Q, 0xC6 not zero, 0xC7 not carry, 0xCC interrupt enable, 0xCD Q, 0xCE zero and 0xCF carry. When the condition holds, `nxt_pc` = `pc_in`+2; otherwise `nxt_pc` = `pc_in`. `jump` and `opnd_bytes` are always 0 for these codes.
- R10: `ctl_hit` is 1 exactly for opcodes 0x30..0x3F and 0xC0..0xCF. Every other opcode gives `nxt_pc` = `pc_in` with `jump`=0 and `opnd_bytes`=0, whatever the flags and operand bytes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| opcode | input | 8 | Instruction byte |
| d_zero | input | 1 | Accumulator equals zero |
| df | input | 1 | Carry flag |
| q | input | 1 | Output latch state |
| ie | input | 1 | Interrupt enable |
| ef | input | EF_N | External sense lines, bit 0 is line 1 |
| pc_in | input | 2*BYTE_W | Program counter, already past the opcode |
| opnd_a | input | BYTE_W | First byte after the opcode |
| opnd_b | input | BYTE_W | Second byte after the opcode |
| out_valid | output | 1 | Results below belong to last cycle's request |
| nxt_pc | output | 2*BYTE_W | Next program counter |
| opnd_bytes | output | 2 | Operand bytes consumed (0, 1 or 2) |
| jump | output | 1 | A branch target was loaded |
| ctl_hit | output | 1 | Opcode is in a control-flow group |

## Verification
The bench sweeps every opcode against every combination of the four flags and four sense lines. The program counters include 0xFFFF, 0xFFFE and values ending in 0xFF, so that page and wrap edges are hit. Several kinds of error are targeted, and each shows up as a wrong `nxt_pc`:
- A design that lets a taken short branch carry into the high byte, or that treats a not-taken short branch as a page-local increment.
- A design that swaps the long-branch byte order.
- A design that applies the same inversion polarity to the skip codes as to the branch codes. This makes 0xC4 skip and 0xCC ignore the interrupt enable.

The bench also checks the held outputs in an idle cycle and a reset that arrives together with a request.

// File: rtl/brsk_pkg.sv
package brsk_pkg;

  typedef enum logic [1:0] {
    K_OTHER = 2'd0,
    K_SHORT = 2'd1,
    K_LBR   = 2'd2,
    K_LSKP  = 2'd3
  } brsk_kind_e;

  typedef struct packed {
    logic d_zero;
    logic df;
    logic q;
    logic ie;
  } brsk_flags_t;

  localparam int OP_W = 8;
  localparam int SEL_W = 3;
  localparam logic [3:0] GRP_SHORT = 4'h3;
  localparam logic [3:0] GRP_LONG  = 4'hC;

endpackage

// File: rtl/brsk_decode.sv
module brsk_decode
  import brsk_pkg::*;
(
  input  logic [OP_W-1:0]  opcode,
  output brsk_kind_e       kind,
  output logic [SEL_W-1:0] sel,
  output logic             invert
);

  always_comb begin
    kind   = K_OTHER;
    sel    = '0;
    invert = 1'b0;
    unique case (opcode[7:4])
      GRP_SHORT: begin
        kind   = K_SHORT;
        sel    = opcode[2:0];
        invert = opcode[3];
      end
      GRP_LONG: begin
        sel = {1'b0, opcode[1:0]};
        if (opcode[2]) begin
          // skip codes use the opposite polarity of bit 3
          kind   = K_LSKP;
          invert = ~opcode[3];
        end else begin
          kind   = K_LBR;
          invert = opcode[3];
        end
      end
      default: begin
        kind = K_OTHER;
      end
    endcase
  end

endmodule

// File: rtl/brsk_cond.sv
module brsk_cond
  import brsk_pkg::*;
#(
  parameter int EF_N = 4
) (
  input  brsk_kind_e       kind,
  input  logic [SEL_W-1:0] sel,
  input  logic             invert,
  input  brsk_flags_t      flags,
  input  logic [EF_N-1:0]  ef,
  output logic             cond
);

  localparam int N_SEL  = 1 << SEL_W;
  localparam int EF_BASE = 4;

  logic [N_SEL-1:0] base_vec;

  // selector 0: unconditional, except the non-inverted skip code tests IE
  assign base_vec[0] = (kind == K_LSKP && !invert) ? flags.ie : 1'b1;
  assign base_vec[1] = flags.q;
  assign base_vec[2] = flags.d_zero;
  assign base_vec[3] = flags.df;

  for (genvar g = 0; g < N_SEL - EF_BASE; g++) begin : g_ef
    if (g < EF_N) begin : g_line
      assign base_vec[EF_BASE + g] = ef[g];
    end else begin : g_tie
      assign base_vec[EF_BASE + g] = 1'b0;
    end
  end

  always_comb begin
    if (kind == K_OTHER) cond = 1'b0;
    else                 cond = base_vec[sel] ^ invert;
  end

endmodule

// File: rtl/brsk_pcgen.sv
module brsk_pcgen
  import brsk_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int PC_W = 2 * BYTE_W
) (
  input  brsk_kind_e        kind,
  input  logic              cond,
  input  logic [PC_W-1:0]   pc,
  input  logic [BYTE_W-1:0] byte_first,
  input  logic [BYTE_W-1:0] byte_second,
  output logic [PC_W-1:0]   pc_next,
  output logic [1:0]        used_bytes,
  output logic              loaded
);

  logic [PC_W-1:0] pc_step1;
  logic [PC_W-1:0] pc_step2;

  assign pc_step1 = pc + PC_W'(1);
  assign pc_step2 = pc + PC_W'(2);

  always_comb begin
    pc_next    = pc;
    used_bytes = 2'd0;
    loaded     = 1'b0;
    unique case (kind)
      K_SHORT: begin
        if (cond) begin
          pc_next    = {pc[PC_W-1:BYTE_W], byte_first};
          used_bytes = 2'd1;
          loaded     = 1'b1;
        end else begin
          pc_next = pc_step1;
        end
      end
      K_LBR: begin
        if (cond) begin
          pc_next    = {byte_first, byte_second};
          used_bytes = 2'd2;
          loaded     = 1'b1;
        end else begin
          pc_next = pc_step2;
        end
      end
      K_LSKP: begin
        pc_next = cond ? pc_step2 : pc;
      end
      default: begin
        pc_next = pc;
      end
    endcase
  end

endmodule

// File: rtl/brsk_unit.sv
module brsk_unit
  import brsk_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int EF_N = 4,
  localparam int PC_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic              d_zero,
  input  logic              df,
  input  logic              q,
  input  logic              ie,
  input  logic [EF_N-1:0]   ef,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [BYTE_W-1:0] opnd_a,
  input  logic [BYTE_W-1:0] opnd_b,
  output logic              out_valid,
  output logic [PC_W-1:0]   nxt_pc,
  output logic [1:0]        opnd_bytes,
  output logic              jump,
  output logic              ctl_hit
);

  brsk_kind_e       kind_c;
  logic [SEL_W-1:0] sel_c;
  logic             inv_c;
  logic             cond_c;
  brsk_flags_t      flags_c;
  logic [PC_W-1:0]  pc_c;
  logic [1:0]       used_c;
  logic             load_c;

  assign flags_c = '{d_zero: d_zero, df: df, q: q, ie: ie};

  brsk_decode u_dec (
    .opcode (opcode),
    .kind   (kind_c),
    .sel    (sel_c),
    .invert (inv_c)
  );

  brsk_cond #(.EF_N(EF_N)) u_cond (
    .kind   (kind_c),
    .sel    (sel_c),
    .invert (inv_c),
    .flags  (flags_c),
    .ef     (ef),
    .cond   (cond_c)
  );

  brsk_pcgen #(.BYTE_W(BYTE_W)) u_pc (
    .kind        (kind_c),
    .cond        (cond_c),
    .pc          (pc_in),
    .byte_first  (opnd_a),
    .byte_second (opnd_b),
    .pc_next     (pc_c),
    .used_bytes  (used_c),
    .loaded      (load_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      nxt_pc     <= '0;
      opnd_bytes <= 2'd0;
      jump       <= 1'b0;
      ctl_hit    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        nxt_pc     <= pc_c;
        opnd_bytes <= used_c;
        jump       <= load_c;
        ctl_hit    <= (kind_c != K_OTHER);
      end
    end
  end

  // R2: a request yields a result one edge later, idle cycles do not
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(nxt_pc)));

  // R4: taken short branch keeps the page, takes the low byte from the operand
  a_r4_short_page: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind_c == K_SHORT && load_c) |=>
      (nxt_pc[PC_W-1:BYTE_W] == $past(pc_in[PC_W-1:BYTE_W]) &&
       nxt_pc[BYTE_W-1:0] == $past(opnd_a) && opnd_bytes == 2'd1));

  // R8: failed long branch steps over both address bytes
  a_r8_long_fall: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind_c == K_LBR && !cond_c) |=>
      (nxt_pc == $past(pc_in) + PC_W'(2) && !jump));

  // R9: skips never load a target or consume operands
  a_r9_skip_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind_c == K_LSKP) |=> (!jump && opnd_bytes == 2'd0));

  // R10: foreign opcodes pass the counter through
  a_r10_passthru: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode[7:4] != GRP_SHORT && opcode[7:4] != GRP_LONG) |=>
      (nxt_pc == $past(pc_in) && !jump && !ctl_hit && opnd_bytes == 2'd0));

endmodule

// File: tb/brsk_unit_tb.sv
module brsk_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [7:0]  opcode;
  logic        d_zero, df, q, ie;
  logic [3:0]  ef;
  logic [15:0] pc_in;
  logic [7:0]  opnd_a, opnd_b;
  logic        out_valid;
  logic [15:0] nxt_pc;
  logic [1:0]  opnd_bytes;
  logic        jump, ctl_hit;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  brsk_unit #(.BYTE_W(8), .EF_N(4)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .d_zero(d_zero), .df(df), .q(q), .ie(ie), .ef(ef),
    .pc_in(pc_in), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .nxt_pc(nxt_pc), .opnd_bytes(opnd_bytes),
    .jump(jump), .ctl_hit(ctl_hit)
  );

  // reference: group code 0 other, 1 short, 2 long branch, 3 skip
  task automatic model(input logic [7:0] op, input logic z, input logic c,
                       input logic qq, input logic en, input logic [3:0] e,
                       input logic [15:0] pc, input logic [7:0] a, input logic [7:0] b,
                       output logic [15:0] epc, output logic [1:0] eby,
                       output logic ej, output logic eh, output string tag);
    int  grp;
    logic t;
    grp = 0; t = 1'b0;
    case (op)
      8'h30: begin grp = 1; t = 1'b1; end
      8'h31: begin grp = 1; t = qq; end
      8'h32: begin grp = 1; t = z; end
      8'h33: begin grp = 1; t = c; end
      8'h34: begin grp = 1; t = e[0]; end
      8'h35: begin grp = 1; t = e[1]; end
      8'h36: begin grp = 1; t = e[2]; end
      8'h37: begin grp = 1; t = e[3]; end
      8'h38: begin grp = 1; t = 1'b0; end
      8'h39: begin grp = 1; t = !qq; end
      8'h3A: begin grp = 1; t = !z; end
      8'h3B: begin grp = 1; t = !c; end
      8'h3C: begin grp = 1; t = !e[0]; end
      8'h3D: begin grp = 1; t = !e[1]; end
      8'h3E: begin grp = 1; t = !e[2]; end
      8'h3F: begin grp = 1; t = !e[3]; end
      8'hC0: begin grp = 2; t = 1'b1; end
      8'hC1: begin grp = 2; t = qq; end
      8'hC2: begin grp = 2; t = z; end
      8'hC3: begin grp = 2; t = c; end
      8'hC8: begin grp = 2; t = 1'b0; end
      8'hC9: begin grp = 2; t = !qq; end
      8'hCA: begin grp = 2; t = !z; end
      8'hCB: begin grp = 2; t = !c; end
      8'hC4: begin grp = 3; t = 1'b0; end
      8'hC5: begin grp = 3; t = !qq; end
      8'hC6: begin grp = 3; t = !z; end
      8'hC7: begin grp = 3; t = !c; end
      8'hCC: begin grp = 3; t = en; end
      8'hCD: begin grp = 3; t = qq; end
      8'hCE: begin grp = 3; t = z; end
      8'hCF: begin grp = 3; t = c; end
      default: grp = 0;
    endcase
    eh = (grp != 0); ej = 1'b0; eby = 2'd0; epc = pc;
    if (grp == 1) begin
      if (t) begin epc = {pc[15:8], a}; ej = 1'b1; eby = 2'd1; tag = "R3/R4"; end
      else begin epc = pc + 16'd1; tag = "R3/R5"; end
    end else if (grp == 2) begin
      if (t) begin epc = {a, b}; ej = 1'b1; eby = 2'd2; tag = "R6/R7"; end
      else begin epc = pc + 16'd2; tag = "R6/R8"; end
    end else if (grp == 3) begin
      epc = t ? pc + 16'd2 : pc; tag = "R9";
    end else begin
      tag = "R10";
    end
  endtask

  task automatic cmp(input string tag, input logic [15:0] epc, input logic [1:0] eby,
                     input logic ej, input logic eh, input logic ev);
    n_cmp++;
    if (nxt_pc !== epc || opnd_bytes !== eby || jump !== ej ||
        ctl_hit !== eh || out_valid !== ev) begin
      n_bad++;
      $display("FAIL %s op=%h: got pc=%h by=%0d j=%b h=%b v=%b exp pc=%h by=%0d j=%b h=%b v=%b",
               tag, opcode, nxt_pc, opnd_bytes, jump, ctl_hit, out_valid,
               epc, eby, ej, eh, ev);
    end
  endtask

  initial begin
    #(8 * 190000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got running exp finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] epc, last_pc;
    logic [1:0]  eby, last_by;
    logic        ej, eh, last_j, last_h;
    string       tag;
    rst = 1'b1; in_valid = 1'b0; opcode = '0; d_zero = 0; df = 0; q = 0; ie = 0;
    ef = '0; pc_in = '0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1 reset", 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;

    for (int op = 0; op < 256; op++) begin
      for (int fl = 0; fl < 256; fl++) begin
        logic [1:0] pk;
        opcode = 8'(op);
        d_zero = fl[0]; df = fl[1]; q = fl[2]; ie = fl[3]; ef = 4'(fl >> 4);
        pk = 2'(fl + op);
        case (pk)
          2'd0: pc_in = 16'hFFFF;
          2'd1: pc_in = {8'(op), 8'hFF};
          2'd2: pc_in = 16'hFFFE;
          default: pc_in = 16'(op * 521 + fl * 97);
        endcase
        opnd_a = 8'(fl) ^ 8'(op) ^ 8'h5A;
        opnd_b = 8'(op + fl * 3);
        in_valid = 1'b1;
        model(opcode, d_zero, df, q, ie, ef, pc_in, opnd_a, opnd_b, epc, eby, ej, eh, tag);
        @(posedge clk);
        @(negedge clk);
        cmp({tag, " R2"}, epc, eby, ej, eh, 1'b1);
      end
    end

    // R2: idle cycle holds results and drops valid
    last_pc = nxt_pc; last_by = opnd_bytes; last_j = jump; last_h = ctl_hit;
    in_valid = 1'b0; opcode = 8'h30; pc_in = 16'h1234;
    @(posedge clk);
    @(negedge clk);
    cmp("R2 idle hold", last_pc, last_by, last_j, last_h, 1'b0);

    // R1: reset wins over a simultaneous request
    in_valid = 1'b1; rst = 1'b1; opcode = 8'hC0; opnd_a = 8'hAB; opnd_b = 8'hCD;
    @(posedge clk);
    @(negedge clk);
    cmp("R1 reset with request", 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0; in_valid = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule